// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block owns the control and erase-block-select registers of an on-chip flash and decides, cycle by cycle, whether the flash may be programmed or erased. Software reaches four byte-wide registers through a simple write/read port. The block combines these settings with a write-enable pin, the system and watchdog resets, a standby request and an error-detect input. From them it produces a program enable, an erase enable, a protection-state code and a sticky error flag.

Three kinds of protection apply. Hardware protection comes from the pin, a reset or standby. It clears the registers and removes both enables at once. Software protection applies while the unlock bit is clear and refuses program/erase bits. Error protection keeps every register setting but blocks program and erase until a reset or standby clears the error flag.

Top module: `flash_prot_ctrl`

## Requirements
- R1: While rst_ni is low and during the two cycles after its release with the pin high, all registers read 0, both enables are 0, err_o is 0 and prot_o is 2 (hardware).
- R2: The pin passes through a two-stage synchronizer. The enables drop within two clock edges of the pin going low. On the next edge, the unlock bit, the control bits and all block bits clear, while the error flag (addr 0 bit 7) is kept.
- R3: A high wdt_rst_i clears all four registers, including the error flag, at the next edge and holds prot_o at 2 while high.
- R4: A high standby_i clears all four registers, including the error flag, and holds prot_o at 2 while high.
- R5: Register writes have no effect while hardware protection is active. Writes to addr 1 have no effect while the unlock bit is 0.
- R6: A write of 1 to both addr 1 bit 0 (program) and bit 1 (erase) is rejected: addr 1 keeps its value and the error flag sets.
- R7: A high err_det_i sets the error flag. Once set, the flag stays set until reset, watchdog reset or standby. While it is set, both enables are 0, writes to addr 1 are ignored and register contents are kept.
- R8: erase_en_o is 1 only when unlock, addr 1 bit 1 and at least one block bit (addr 2 = blocks 0..7, addr 3 = blocks 8..15) are set, and no protection is active.
- R9: prog_en_o is 1 exactly when unlock and addr 1 bit 0 are set and no hardware or error protection is active. The two enables are never high together.
- R10: prot_o encodes 0 none, 1 software, 2 hardware, 3 error, with priority hardware over error over software.
- R11: Register map: addr 0 bit 0 is unlock and bit 7 is the read-only error flag. rdata_o returns the register selected by addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| wdt_rst_i | input | 1 | Synchronous watchdog reset |
| standby_i | input | 1 | Standby request |
| fwe_i | input | 1 | Asynchronous flash write-enable pin level |
| err_det_i | input | 1 | Error detected during program/erase |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| prog_en_o | output | 1 | Program allowed |
| erase_en_o | output | 1 | Erase allowed |
| prot_o | output | 2 | Protection state code |
| err_o | output | 1 | Sticky error flag |

## Verification
The bench drops the pin while the error flag is set. A design that cleared the flag on the pin path would read 0x00 at addr 0 instead of 0x80 and would report software protection instead of error protection. A write of both program and erase is sent. A design that accepted it would drive both enables, or would leave the error flag clear. The erase enable is watched as the last selected block is deselected, which catches an ungated erase. The exact cycle in which the enables drop after the pin falls is checked, which exposes a missing or extra synchronizer stage.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    PROT_NONE = 2'd0,
    PROT_SOFT = 2'd1,
    PROT_HARD = 2'd2,
    PROT_ERR  = 2'd3
  } prot_e;

  localparam logic [1:0] ADDR_CTLA  = 2'd0;
  localparam logic [1:0] ADDR_CTLB  = 2'd1;
  localparam logic [1:0] ADDR_BLKLO = 2'd2;
  localparam logic [1:0] ADDR_BLKHI = 2'd3;

  localparam int UNLOCK_BIT = 0;
  localparam int ERRFLG_BIT = 7;
  localparam int PROG_BIT   = 0;
  localparam int ERASE_BIT  = 1;
endpackage

// File: rtl/fpc_sync.sv
module fpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  // resets low: protected until the pin is seen high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/fpc_regs.sv
module fpc_regs
  import fpc_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NBLK = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wdt_rst_i,
  input  logic            standby_i,
  input  logic            fwe_s_i,
  input  logic            err_det_i,
  input  logic            wr_en_i,
  input  logic [1:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            unlock_o,
  output logic            prog_o,
  output logic            erase_o,
  output logic [NBLK-1:0] blk_o,
  output logic            err_o
);
  localparam int BLK_W = NBLK / 2;

  logic            unlock_q, prog_q, erase_q, err_q;
  logic [NBLK-1:0] blk_q;
  logic            clr_all, ctlb_ok, bad_wr;

  assign clr_all = wdt_rst_i | standby_i;
  assign ctlb_ok = fwe_s_i & wr_en_i & (addr_i == ADDR_CTLB) & unlock_q & ~err_q;
  assign bad_wr  = ctlb_ok & wdata_i[PROG_BIT] & wdata_i[ERASE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q <= 1'b0;
      prog_q   <= 1'b0;
      erase_q  <= 1'b0;
      err_q    <= 1'b0;
      blk_q    <= '0;
    end else if (clr_all) begin
      unlock_q <= 1'b0;
      prog_q   <= 1'b0;
      erase_q  <= 1'b0;
      err_q    <= 1'b0;
      blk_q    <= '0;
    end else begin
      if (err_det_i || bad_wr) err_q <= 1'b1;
      if (!fwe_s_i) begin
        // pin path: error flag survives
        unlock_q <= 1'b0;
        prog_q   <= 1'b0;
        erase_q  <= 1'b0;
        blk_q    <= '0;
      end else if (wr_en_i) begin
        unique case (addr_i)
          ADDR_CTLA:  unlock_q <= wdata_i[UNLOCK_BIT];
          ADDR_CTLB:  if (ctlb_ok && !bad_wr) begin
                        prog_q  <= wdata_i[PROG_BIT];
                        erase_q <= wdata_i[ERASE_BIT];
                      end
          ADDR_BLKLO: blk_q[BLK_W-1:0]    <= wdata_i[BLK_W-1:0];
          ADDR_BLKHI: blk_q[NBLK-1:BLK_W] <= wdata_i[BLK_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTLA: begin
        rdata_o[UNLOCK_BIT] = unlock_q;
        rdata_o[ERRFLG_BIT] = err_q;
      end
      ADDR_CTLB: begin
        rdata_o[PROG_BIT]  = prog_q;
        rdata_o[ERASE_BIT] = erase_q;
      end
      ADDR_BLKLO: rdata_o[BLK_W-1:0] = blk_q[BLK_W-1:0];
      ADDR_BLKHI: rdata_o[BLK_W-1:0] = blk_q[NBLK-1:BLK_W];
      default: ;
    endcase
  end

  assign unlock_o = unlock_q;
  assign prog_o   = prog_q;
  assign erase_o  = erase_q;
  assign blk_o    = blk_q;
  assign err_o    = err_q;

  AST_PIN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwe_s_i && !clr_all) |=> (!unlock_q && !prog_q && !erase_q && blk_q == '0)); // R2
  AST_PIN_KEEPS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwe_s_i && err_q && !clr_all) |=> err_q); // R2
  AST_WDT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_i |=> (!err_q && !unlock_q && !prog_q && !erase_q && blk_q == '0)); // R3
  AST_STBY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (!err_q && !unlock_q && !prog_q && !erase_q && blk_q == '0)); // R4
  AST_BOTH_REJECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_CTLB && wdata_i[1:0] == 2'b11 && !clr_all)
      |=> !(prog_q && erase_q)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clr_all) |=> err_q); // R7
  AST_ERR_HOLDS_CTL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && fwe_s_i && !clr_all) |=> ($stable(prog_q) && $stable(erase_q))); // R7
endmodule

// File: rtl/fpc_gate.sv
module fpc_gate
  import fpc_pkg::*;
#(
  parameter int NBLK = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fwe_s_i,
  input  logic            wdt_rst_i,
  input  logic            standby_i,
  input  logic            unlock_i,
  input  logic            prog_i,
  input  logic            erase_i,
  input  logic [NBLK-1:0] blk_i,
  input  logic            err_i,
  output logic            prog_en_o,
  output logic            erase_en_o,
  output logic [1:0]      prot_o
);
  logic  hw_prot, go;
  prot_e prot;

  assign hw_prot = ~fwe_s_i | wdt_rst_i | standby_i;
  assign go      = ~hw_prot & ~err_i & unlock_i;

  assign prog_en_o  = go & prog_i & ~erase_i;
  assign erase_en_o = go & erase_i & ~prog_i & (|blk_i);

  always_comb begin
    if (hw_prot)       prot = PROT_HARD;
    else if (err_i)    prot = PROT_ERR;
    else if (!unlock_i) prot = PROT_SOFT;
    else               prot = PROT_NONE;
  end
  assign prot_o = prot;

  AST_HW_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fwe_s_i |-> (!prog_en_o && !erase_en_o)); // R2
  AST_ERR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> (!prog_en_o && !erase_en_o)); // R7
  AST_ERASE_NEEDS_BLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_en_o |-> (blk_i != '0)); // R8
  AST_EN_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({prog_en_o, erase_en_o}) <= 1); // R9
endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl
  import fpc_pkg::*;
#(
  parameter int DW          = 8,
  parameter int NBLK        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wdt_rst_i,
  input  logic          standby_i,
  input  logic          fwe_i,
  input  logic          err_det_i,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          prog_en_o,
  output logic          erase_en_o,
  output logic [1:0]    prot_o,
  output logic          err_o
);
  logic            fwe_s, unlock, prog, erase, err;
  logic [NBLK-1:0] blk;

  fpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (fwe_i),
    .q_o   (fwe_s)
  );

  fpc_regs #(.DW(DW), .NBLK(NBLK)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wdt_rst_i(wdt_rst_i),
    .standby_i(standby_i),
    .fwe_s_i  (fwe_s),
    .err_det_i(err_det_i),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .unlock_o (unlock),
    .prog_o   (prog),
    .erase_o  (erase),
    .blk_o    (blk),
    .err_o    (err)
  );

  fpc_gate #(.NBLK(NBLK)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fwe_s_i   (fwe_s),
    .wdt_rst_i (wdt_rst_i),
    .standby_i (standby_i),
    .unlock_i  (unlock),
    .prog_i    (prog),
    .erase_i   (erase),
    .blk_i     (blk),
    .err_i     (err),
    .prog_en_o (prog_en_o),
    .erase_en_o(erase_en_o),
    .prot_o    (prot_o)
  );

  assign err_o = err;
endmodule

// File: tb/tb_flash_prot_ctrl.sv
module tb_flash_prot_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni, wdt_rst_i, standby_i, fwe_i, err_det_i, wr_en_i;
  logic [1:0] addr_i;
  logic [7:0] wdata_i, rdata_o;
  logic       prog_en_o, erase_en_o, err_o;
  logic [1:0] prot_o;

  logic n_rst = 1'b0, n_wdt = 1'b0, n_stby = 1'b0, n_fwe = 1'b1, n_err = 1'b0;

  typedef struct {
    logic       p, e, er;
    logic [1:0] pr;
    logic [7:0] rd;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  flash_prot_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .wdt_rst_i(wdt_rst_i), .standby_i(standby_i),
    .fwe_i(fwe_i), .err_det_i(err_det_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .prog_en_o(prog_en_o),
    .erase_en_o(erase_en_o), .prot_o(prot_o), .err_o(err_o)
  );

  task automatic step(input logic wr, input logic [1:0] a, input logic [7:0] d,
                      input logic ep, input logic ee, input logic [1:0] epr,
                      input logic eer, input logic [7:0] erd, input string tag);
    exp_t x;
    @(negedge clk);
    rst_ni = n_rst; wdt_rst_i = n_wdt; standby_i = n_stby;
    fwe_i = n_fwe; err_det_i = n_err;
    wr_en_i = wr; addr_i = a; wdata_i = d;
    @(posedge clk);
    x.p = ep; x.e = ee; x.pr = epr; x.er = eer; x.rd = erd; x.tag = tag;
    sb_q.push_back(x);
  endtask

  // monitor: sample after the edge, before the next input change
  always @(posedge clk) begin
    #3;
    while (sb_q.size() > 0) begin
      exp_t x;
      x = sb_q.pop_front();
      n_chk++;
      if (prog_en_o !== x.p || erase_en_o !== x.e || prot_o !== x.pr ||
          err_o !== x.er || rdata_o !== x.rd) begin
        n_bad++;
        $display("FAIL %s: got p=%b e=%b prot=%0d err=%b rd=%h exp p=%b e=%b prot=%0d err=%b rd=%h",
                 x.tag, prog_en_o, erase_en_o, prot_o, err_o, rdata_o,
                 x.p, x.e, x.pr, x.er, x.rd);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang exp finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; wdt_rst_i = 0; standby_i = 0; fwe_i = 1; err_det_i = 0;
    wr_en_i = 0; addr_i = 0; wdata_i = 0;
    step(0, 0, 8'h00, 0, 0, 2, 0, 8'h00, "R1 in reset");
    n_rst = 1;
    step(0, 0, 8'h00, 0, 0, 2, 0, 8'h00, "R1 sync stage");
    step(0, 0, 8'h00, 0, 0, 1, 0, 8'h00, "R10 software protect");
    step(1, 1, 8'h01, 0, 0, 1, 0, 8'h00, "R5 locked ctl write");
    step(1, 0, 8'h01, 0, 0, 0, 0, 8'h01, "R11 unlock bit");
    step(1, 1, 8'h01, 1, 0, 0, 0, 8'h01, "R9 program enable");
    step(1, 1, 8'h03, 0, 0, 3, 1, 8'h01, "R6 both rejected");
    step(1, 1, 8'h00, 0, 0, 3, 1, 8'h01, "R7 ctl write in error");
    step(0, 0, 8'h00, 0, 0, 3, 1, 8'h81, "R11 error flag bit7");
    n_wdt = 1;
    step(0, 0, 8'h00, 0, 0, 2, 0, 8'h00, "R3 watchdog clears");
    n_wdt = 0;
    step(0, 0, 8'h00, 0, 0, 1, 0, 8'h00, "R3 after watchdog");
    step(1, 0, 8'h01, 0, 0, 0, 0, 8'h01, "R11 unlock again");
    step(1, 3, 8'h80, 0, 0, 0, 0, 8'h80, "R11 block hi");
    step(1, 1, 8'h02, 0, 1, 0, 0, 8'h02, "R8 erase enable");
    step(1, 3, 8'h00, 0, 0, 0, 0, 8'h00, "R8 no block");
    step(1, 2, 8'h01, 0, 1, 0, 0, 8'h01, "R8 block lo");
    n_err = 1;
    step(0, 2, 8'h00, 0, 0, 3, 1, 8'h01, "R7 error keeps blocks");
    n_err = 0;
    step(0, 1, 8'h00, 0, 0, 3, 1, 8'h02, "R7 ctl kept");
    n_fwe = 0;
    step(0, 0, 8'h00, 0, 0, 3, 1, 8'h81, "R2 sync first stage");
    step(0, 0, 8'h00, 0, 0, 2, 1, 8'h81, "R2 protected");
    step(0, 0, 8'h00, 0, 0, 2, 1, 8'h80, "R2 cleared keeps error");
    step(0, 2, 8'h00, 0, 0, 2, 1, 8'h00, "R2 blocks cleared");
    step(1, 0, 8'h01, 0, 0, 2, 1, 8'h80, "R5 write under hardware");
    n_fwe = 1;
    step(0, 0, 8'h00, 0, 0, 2, 1, 8'h80, "R2 resync");
    step(0, 0, 8'h00, 0, 0, 3, 1, 8'h80, "R10 error priority");
    n_stby = 1;
    step(0, 0, 8'h00, 0, 0, 2, 0, 8'h00, "R4 standby clears");
    n_stby = 0;
    step(0, 0, 8'h00, 0, 0, 1, 0, 8'h00, "R4 after standby");
    step(1, 0, 8'h01, 0, 0, 0, 0, 8'h01, "R11 unlock");
    step(1, 1, 8'h01, 1, 0, 0, 0, 8'h01, "R9 program");
    n_fwe = 0;
    step(0, 1, 8'h00, 1, 0, 0, 0, 8'h01, "R2 first edge still on");
    step(0, 1, 8'h00, 0, 0, 2, 0, 8'h01, "R2 dropped by second edge");
    step(0, 1, 8'h00, 0, 0, 2, 0, 8'h00, "R2 ctl cleared");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule